// File: doc/BRIEF.md
# Configuration Bitstream Frame Checker

This block watches a serial configuration bitstream that arrives one bit per clock, with a valid strobe on the bits that count. It locates each frame from its start pair and reads a two-bit frame type. It skips the alignment padding and passes the payload bits out with a strobe. After the payload it checks a trailing XOR checksum byte, and it counts out the stop bits. For ID frames the payload is also compared with a fixed device code.

Three faults can occur. A stop-bit history containing a zero when a new start pair shows up is an alignment fault. A checksum that does not close to zero is a checksum fault. An ID payload that differs from the device code is an ID fault. Any fault parks the checker in a sticky fault state: the active-low `init_n` output drops and a two-bit error code reports the first fault seen. Only the reset input or a program request brings the checker back to hunting for a frame. Writing the payload into configuration storage is left to the logic downstream.

Top module: `cfg_frame_checker`

## Requirements
- R1: After reset `init_n` is 1, `err_code` is 00, and `pay_vld` and `frame_ok` are 0.
- R2: A frame on the accepted bits (those with `bit_vld` high) has these fields in order. First the start pair 0 then 1. Next a 2-bit type, MSB first, where 00 is ID, 01 is address, 10 is data and 11 is handled as data. Then `PAD_BITS` padding bits, then `PAYLOAD_BITS` payload bits MSB first, then 8 checksum bits MSB first, then `STOP_BITS` stop bits. Cycles with `bit_vld` low change nothing, whatever `bit_in` carries.
- R3: Each payload bit appears on `pay_bit` with `pay_vld` high and `pay_type` equal to the frame type, in the cycle after it is accepted. Type, padding, checksum and stop bits never raise `pay_vld`.
- R4: The checksum byte must equal the XOR of the payload bytes; type and padding bits do not enter it. A mismatch sets `err_code` to 11. A match gives a one-cycle `frame_ok` pulse in the cycle after the last checksum bit.
- R5: When the 1 of a start pair is accepted and any of the `STOP_BITS` bits accepted just before the pair's 0 was 0, `err_code` becomes 10. After reset or a program request, this history counts as all ones.
- R6: In an ID-type frame, the payload is compared with `DEV_CODE`. Any difference sets `err_code` to 01 in the cycle after the last payload bit, before the checksum is read. Other frame types are not compared.
- R7: A fault sets `err_code` and drives `init_n` low in the cycle after the bit that caused it.
- R8: Only the first fault is kept. While in the fault state, accepted bits are ignored: `err_code` holds, and `pay_vld` and `frame_ok` stay 0.
- R9: A `prog` pulse clears the fault, restores the all-ones stop history and restarts the hunt for a start pair. A bit offered in the same cycle as `prog` is dropped.
- R10: Asserting `rst_n` low also clears a fault.
- R11: Frames may follow one another with no gap, and the next start pair may come straight after the last stop bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog | input | 1 | Program request: clears fault and restarts frame search |
| bit_in | input | 1 | Serial bitstream bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| init_n | output | 1 | Low while in the fault state |
| err_code | output | 2 | First fault: 00 none, 01 ID, 10 alignment, 11 checksum |
| pay_vld | output | 1 | `pay_bit` carries a payload bit |
| pay_bit | output | 1 | Payload bit, MSB first |
| pay_type | output | 2 | Type of the frame the payload bit belongs to |
| frame_ok | output | 1 | One-cycle pulse when a frame's checksum closes |

## Verification
A wrong field count or a phase that slips shows up within one frame. The payload captured from `pay_vld` no longer matches, or a good checksum is rejected at the frame's last checksum bit. A stale stop history or a missed clear only appears one frame later, as an alignment code raised on the start pair's 1 bit, so the bench checks the code on that exact bit. A fault that is not sticky, or an ID compare that runs late, shows up as a wrong `err_code` or as a `pay_vld`/`frame_ok` pulse after the fault. The bench therefore checks the code bit by bit around the offending bit.

// File: rtl/cfgchk_pkg.sv
package cfgchk_pkg;

    typedef enum logic [2:0] {
        PH_HUNT,
        PH_PAIR,
        PH_TYPE,
        PH_PAD,
        PH_BODY,
        PH_SUM,
        PH_STOP,
        PH_FAULT
    } phase_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'b00,
        ERR_ID    = 2'b01,
        ERR_ALIGN = 2'b10,
        ERR_SUM   = 2'b11
    } err_e;

    localparam logic [1:0] FT_ID   = 2'b00;
    localparam logic [1:0] FT_ADDR = 2'b01;
    localparam logic [1:0] FT_DATA = 2'b10;

    localparam int TYPE_W = 2;
    localparam int SUM_W  = 8;

endpackage

// File: rtl/cfgchk_stop_hist.sv
module cfgchk_stop_hist #(
    parameter int STOP_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic bit_in,
    output logic all_ones
);

    typedef struct packed {
        logic [STOP_BITS-1:0] hist;
    } hist_t;

    hist_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.hist = '1;
        end else if (en) begin
            st_d.hist = {st_q.hist[STOP_BITS-2:0], bit_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hist <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign all_ones = &st_q.hist;

    // R5: a cleared history reads as all ones on the next cycle
    a_r5_hist_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> all_ones);

endmodule

// File: rtl/cfgchk_xsum.sv
module cfgchk_xsum #(
    parameter int BYTE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic bit_in,
    output logic close_zero
);

    localparam int BC_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [BC_W-1:0]   bc;
        logic [BYTE_W-1:0] acc;
    } xs_t;

    xs_t st_d, st_q;
    logic [BYTE_W-1:0] byte_now;
    logic              byte_end;

    assign byte_now = {st_q.sh[BYTE_W-2:0], bit_in};
    assign byte_end = en && (st_q.bc == BC_W'(BYTE_W-1));

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (en) begin
            st_d.sh = byte_now;
            st_d.bc = st_q.bc + 1'b1;
            if (byte_end) begin
                st_d.acc = st_q.acc ^ byte_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign close_zero = byte_end && ((st_q.acc ^ byte_now) == '0);

    // R4: every frame starts counting bytes from a clean boundary
    a_r4_byte_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.bc == '0 && st_q.acc == '0));

endmodule

// File: rtl/cfgchk_idcmp.sv
module cfgchk_idcmp #(
    parameter int               ID_W    = 32,
    parameter logic [ID_W-1:0]  ID_CODE = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic bit_in,
    output logic mism_now
);

    typedef struct packed {
        logic [ID_W-1:0] expect_sh;
        logic            mism;
    } id_t;

    id_t  st_d, st_q;
    logic bit_diff;

    assign bit_diff = en && (bit_in != st_q.expect_sh[ID_W-1]);

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.expect_sh = ID_CODE;
            st_d.mism      = 1'b0;
        end else if (en) begin
            st_d.expect_sh = {st_q.expect_sh[ID_W-2:0], 1'b0};
            st_d.mism      = st_q.mism | bit_diff;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.expect_sh <= ID_CODE;
            st_q.mism      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mism_now = st_q.mism | bit_diff;

    // R6: once a differing bit is seen it stays recorded until the frame restarts
    a_r6_mismatch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mism && !clr) |=> st_q.mism);

endmodule

// File: rtl/cfg_frame_checker.sv
module cfg_frame_checker
    import cfgchk_pkg::*;
#(
    parameter int                      PAYLOAD_BITS = 32,
    parameter int                      PAD_BITS     = 2,
    parameter int                      STOP_BITS    = 8,
    parameter logic [PAYLOAD_BITS-1:0] DEV_CODE     = 32'hA5C3_1E07
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog,
    input  logic       bit_in,
    input  logic       bit_vld,
    output logic       init_n,
    output logic [1:0] err_code,
    output logic       pay_vld,
    output logic       pay_bit,
    output logic [1:0] pay_type,
    output logic       frame_ok
);

    localparam int MAX_LEN = (PAYLOAD_BITS > STOP_BITS) ? PAYLOAD_BITS : STOP_BITS;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       ftype;
        logic             cand_ok;
        err_e             err;
        logic             pay_vld;
        logic             pay_bit;
        logic             frame_ok;
    } chk_t;

    localparam chk_t ST_RST = '{
        phase:    PH_HUNT,
        cnt:      '0,
        ftype:    FT_ID,
        cand_ok:  1'b1,
        err:      ERR_NONE,
        pay_vld:  1'b0,
        pay_bit:  1'b0,
        frame_ok: 1'b0
    };

    chk_t st_d, st_q;

    logic take;
    logic frm_clr;
    logic xs_en;
    logic id_en;
    logic hist_ones;
    logic xs_zero;
    logic id_mism;
    logic aux_clr;

    assign take    = bit_vld && (st_q.phase != PH_FAULT) && !prog;
    assign aux_clr = prog || frm_clr;

    cfgchk_stop_hist #(
        .STOP_BITS (STOP_BITS)
    ) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (prog),
        .en       (take),
        .bit_in   (bit_in),
        .all_ones (hist_ones)
    );

    cfgchk_xsum #(
        .BYTE_W (SUM_W)
    ) u_xsum (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (aux_clr),
        .en         (xs_en),
        .bit_in     (bit_in),
        .close_zero (xs_zero)
    );

    cfgchk_idcmp #(
        .ID_W    (PAYLOAD_BITS),
        .ID_CODE (DEV_CODE)
    ) u_idcmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (aux_clr),
        .en       (id_en),
        .bit_in   (bit_in),
        .mism_now (id_mism)
    );

    always_comb begin
        st_d          = st_q;
        st_d.pay_vld  = 1'b0;
        st_d.frame_ok = 1'b0;
        frm_clr       = 1'b0;
        xs_en         = 1'b0;
        id_en         = 1'b0;

        if (prog) begin
            st_d = ST_RST;
        end else if (take) begin
            unique case (st_q.phase)
                PH_HUNT: begin
                    if (!bit_in) begin
                        st_d.cand_ok = hist_ones;
                        st_d.phase   = PH_PAIR;
                    end
                end
                PH_PAIR: begin
                    if (bit_in) begin
                        if (st_q.cand_ok) begin
                            st_d.phase = PH_TYPE;
                            st_d.cnt   = '0;
                            frm_clr    = 1'b1;
                        end else begin
                            st_d.phase = PH_FAULT;
                            st_d.err   = ERR_ALIGN;
                        end
                    end else begin
                        st_d.cand_ok = hist_ones;
                    end
                end
                PH_TYPE: begin
                    st_d.ftype = {st_q.ftype[0], bit_in};
                    st_d.cnt   = st_q.cnt + 1'b1;
                    if (st_q.cnt == CNT_W'(TYPE_W - 1)) begin
                        st_d.cnt   = '0;
                        st_d.phase = (PAD_BITS == 0) ? PH_BODY : PH_PAD;
                    end
                end
                PH_PAD: begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (st_q.cnt == CNT_W'(PAD_BITS - 1)) begin
                        st_d.cnt   = '0;
                        st_d.phase = PH_BODY;
                    end
                end
                PH_BODY: begin
                    xs_en        = 1'b1;
                    id_en        = (st_q.ftype == FT_ID);
                    st_d.pay_vld = 1'b1;
                    st_d.pay_bit = bit_in;
                    st_d.cnt     = st_q.cnt + 1'b1;
                    if (st_q.cnt == CNT_W'(PAYLOAD_BITS - 1)) begin
                        st_d.cnt = '0;
                        if ((st_q.ftype == FT_ID) && id_mism) begin
                            st_d.phase = PH_FAULT;
                            st_d.err   = ERR_ID;
                        end else begin
                            st_d.phase = PH_SUM;
                        end
                    end
                end
                PH_SUM: begin
                    xs_en    = 1'b1;
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (st_q.cnt == CNT_W'(SUM_W - 1)) begin
                        st_d.cnt = '0;
                        if (xs_zero) begin
                            st_d.phase    = PH_STOP;
                            st_d.frame_ok = 1'b1;
                        end else begin
                            st_d.phase = PH_FAULT;
                            st_d.err   = ERR_SUM;
                        end
                    end
                end
                PH_STOP: begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (st_q.cnt == CNT_W'(STOP_BITS - 1)) begin
                        st_d.cnt   = '0;
                        st_d.phase = PH_HUNT;
                    end
                end
                default: begin
                    st_d.phase = PH_FAULT;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign init_n   = (st_q.phase != PH_FAULT);
    assign err_code = st_q.err;
    assign pay_vld  = st_q.pay_vld;
    assign pay_bit  = st_q.pay_bit;
    assign pay_type = st_q.ftype;
    assign frame_ok = st_q.frame_ok;

    // R7: the fault line and the error code always agree
    a_r7_init_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
        init_n == (err_code == 2'b00));

    // R8: a recorded fault keeps its code until a program request
    a_r8_code_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 2'b00 && !prog) |=> (err_code == $past(err_code)));

    // R8: no payload and no frame pulse once the fault state has been entered
    a_r8_quiet_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n |=> (!pay_vld && !frame_ok));

    // R4: a good-frame pulse never coexists with a fault
    a_r4_ok_without_fault: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> init_n);

    // R9: a program request always leaves the checker clear and searching
    a_r9_prog_clears: assert property (@(posedge clk) disable iff (!rst_n)
        prog |=> (init_n && err_code == 2'b00 && !pay_vld));

endmodule

// File: tb/cfg_frame_checker_bench.sv
module cfg_frame_checker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PB   = 32;
    localparam int PD   = 2;
    localparam int SB   = 8;
    localparam logic [PB-1:0] DEV = 32'hA5C3_1E07;
    localparam int FLEN = 2 + 2 + PD + PB + 8 + SB;
    localparam int PAY0 = 4 + PD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog = 1'b0;
    logic       bit_in = 1'b1;
    logic       bit_vld = 1'b0;
    logic       init_n;
    logic [1:0] err_code;
    logic       pay_vld;
    logic       pay_bit;
    logic [1:0] pay_type;
    logic       frame_ok;

    int total = 0;
    int bad = 0;
    int pay_n = 0;
    int ok_n = 0;
    logic [PB-1:0] pay_rx = '0;
    logic [1:0]    last_type = '0;
    logic          fb [0:FLEN-1];
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_frame_checker #(
        .PAYLOAD_BITS (PB),
        .PAD_BITS     (PD),
        .STOP_BITS    (SB),
        .DEV_CODE     (DEV)
    ) u_cfg_frame_checker (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog     (prog),
        .bit_in   (bit_in),
        .bit_vld  (bit_vld),
        .init_n   (init_n),
        .err_code (err_code),
        .pay_vld  (pay_vld),
        .pay_bit  (pay_bit),
        .pay_type (pay_type),
        .frame_ok (frame_ok)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sample();
        if (pay_vld) begin
            pay_rx    = {pay_rx[PB-2:0], pay_bit};
            pay_n++;
            last_type = pay_type;
        end
        if (frame_ok) ok_n++;
    endtask

    task automatic push(input logic b);
        @(negedge clk);
        prog    = 1'b0;
        bit_in  = b;
        bit_vld = 1'b1;
        @(posedge clk);
        #1;
        sample();
    endtask

    task automatic idle_cyc(input logic junk);
        @(negedge clk);
        prog    = 1'b0;
        bit_in  = junk;
        bit_vld = 1'b0;
        @(posedge clk);
        #1;
        sample();
    endtask

    task automatic clr_mon();
        pay_n  = 0;
        ok_n   = 0;
        pay_rx = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        bit_vld = 1'b0;
        prog    = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic build(input logic [1:0] ty, input logic [PB-1:0] pl,
                         input logic [PD-1:0] pad, input logic [7:0] flip,
                         input logic [SB-1:0] stop);
        logic [7:0] x;
        x = '0;
        for (int i = 0; i < PB/8; i++) x ^= pl[PB-1-8*i -: 8];
        x ^= flip;
        fb[0] = 1'b0;
        fb[1] = 1'b1;
        fb[2] = ty[1];
        fb[3] = ty[0];
        for (int i = 0; i < PD; i++) fb[4+i] = pad[PD-1-i];
        for (int i = 0; i < PB; i++) fb[PAY0+i] = pl[PB-1-i];
        for (int i = 0; i < 8; i++)  fb[PAY0+PB+i] = x[7-i];
        for (int i = 0; i < SB; i++) fb[PAY0+PB+8+i] = stop[SB-1-i];
    endtask

    task automatic push_range(input int a, input int b, input bit gaps);
        for (int i = a; i <= b; i++) begin
            push(fb[i]);
            if (gaps && (i % 3 == 0)) idle_cyc(~fb[i]);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 init_n", 32'(init_n), 32'd1);
        check("R1 err_code", 32'(err_code), 32'd0);
        check("R1 pay_vld", 32'(pay_vld), 32'd0);
        check("R1 frame_ok", 32'(frame_ok), 32'd0);
    endtask

    task automatic t_data_gaps();
        clr_mon();
        build(2'b10, 32'h1234_5678, 2'b11, 8'h00, '1);
        push_range(0, FLEN-1, 1'b1);
        check("R2 payload count", 32'(pay_n), 32'd32);
        check("R3 payload value", pay_rx, 32'h1234_5678);
        check("R3 payload type", 32'(last_type), 32'd2);
        check("R4 good frame pulse", 32'(ok_n), 32'd1);
        check("R4 no error", 32'(err_code), 32'd0);
    endtask

    task automatic t_back_to_back();
        clr_mon();
        build(2'b01, 32'hDEAD_BEEF, 2'b00, 8'h00, '1);
        push_range(0, FLEN-1, 1'b0);
        check("R3 address type", 32'(last_type), 32'd1);
        build(2'b00, DEV, 2'b01, 8'h00, '1);
        push_range(0, FLEN-1, 1'b0);
        check("R11 two frames ok", 32'(ok_n), 32'd2);
        check("R6 matching id", 32'(err_code), 32'd0);
        check("R3 id payload", pay_rx, DEV);
    endtask

    task automatic t_reserved_type();
        clr_mon();
        build(2'b11, 32'h0F0F_00FF, 2'b10, 8'h00, '1);
        push_range(0, FLEN-1, 1'b0);
        check("R2 reserved type as data ok", 32'(ok_n), 32'd1);
        check("R2 reserved type value", 32'(last_type), 32'd3);
    endtask

    task automatic t_sum_error();
        clr_mon();
        build(2'b10, 32'hCAFE_0001, 2'b00, 8'h01, '1);
        push_range(0, PAY0+PB+6, 1'b0);
        check("R4 before last sum bit", 32'(err_code), 32'd0);
        push_range(PAY0+PB+7, PAY0+PB+7, 1'b0);
        check("R4 checksum code", 32'(err_code), 32'd3);
        check("R7 init low", 32'(init_n), 32'd0);
        check("R4 no pulse on bad frame", 32'(ok_n), 32'd0);
        push_range(PAY0+PB+8, FLEN-1, 1'b0);
        clr_mon();
        build(2'b10, 32'h0000_0042, 2'b00, 8'h00, '1);
        push_range(0, FLEN-1, 1'b0);
        check("R8 code held", 32'(err_code), 32'd3);
        check("R8 no payload in fault", 32'(pay_n), 32'd0);
        check("R8 no pulse in fault", 32'(ok_n), 32'd0);
        @(negedge clk);
        prog    = 1'b1;
        bit_in  = 1'b0;
        bit_vld = 1'b1;
        @(posedge clk);
        #1;
        check("R9 cleared code", 32'(err_code), 32'd0);
        check("R9 init high", 32'(init_n), 32'd1);
        clr_mon();
        build(2'b10, 32'h7777_1111, 2'b00, 8'h00, '1);
        push_range(0, FLEN-1, 1'b0);
        check("R9 bit with prog dropped", 32'(err_code), 32'd0);
        check("R9 frame after prog", 32'(ok_n), 32'd1);
    endtask

    task automatic t_id_error();
        clr_mon();
        build(2'b00, DEV ^ 32'h1, 2'b00, 8'h5A, '1);
        push_range(0, PAY0+PB-2, 1'b0);
        check("R6 before last id bit", 32'(err_code), 32'd0);
        push_range(PAY0+PB-1, PAY0+PB-1, 1'b0);
        check("R6 id code", 32'(err_code), 32'd1);
        check("R7 init low on id", 32'(init_n), 32'd0);
        push_range(PAY0+PB, FLEN-1, 1'b0);
        check("R8 first fault kept", 32'(err_code), 32'd1);
        check("R8 no pulse", 32'(ok_n), 32'd0);
    endtask

    task automatic t_align_error();
        do_reset();
        clr_mon();
        build(2'b10, 32'h1357_9BDF, 2'b00, 8'h00, 8'hFB);
        push_range(0, FLEN-1, 1'b0);
        check("R5 bad stop frame itself ok", 32'(ok_n), 32'd1);
        build(2'b10, 32'h2468_ACE0, 2'b00, 8'h00, '1);
        push_range(0, 0, 1'b0);
        check("R5 no error on pair zero", 32'(err_code), 32'd0);
        push_range(1, 1, 1'b0);
        check("R5 alignment code", 32'(err_code), 32'd2);
        check("R7 init low on align", 32'(init_n), 32'd0);
        do_reset();
        check("R10 reset clears code", 32'(err_code), 32'd0);
        check("R10 reset init high", 32'(init_n), 32'd1);
        clr_mon();
        push_range(0, FLEN-1, 1'b0);
        check("R10 frame after reset", 32'(ok_n), 32'd1);
    endtask

    initial begin
        t_reset();
        t_data_gaps();
        t_back_to_back();
        t_reserved_type();
        t_sum_error();
        t_id_error();
        t_align_error();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule